// File: doc/BRIEF.md
# Stream end-marker embedding inserter

This block sits on a 64-bit valid/ready stream that also carries a last flag. It removes that flag by folding it into the data, so the stream can cross a link that carries data words only. It does this with a reserved escape word (0xDEADBEEFFEEDCAFE). A word flagged as last leaves as three words: the escape word, a control word equal to 1, and then the payload. A payload that happens to equal the escape word is protected the same way, but with a control word of 0. Every other word passes through unchanged.

A receiver that sees the escape word treats the next word as control. It treats the word after that as payload, and sets last on the payload only when the control value was 1. The output comes from a two-entry registered buffer. Input ready is derived from registered state only, so there is no combinational path from output ready to input ready.

Top module: `tagfold_inserter`

## Requirements
- R1: A word with in_last=0 whose data is not the escape word appears on the output once, unchanged, and in input order.
- R2: A word with in_last=1 produces three output words: the escape word 0xDEADBEEFFEEDCAFE, then the control word 64'h1, then the original data.
- R3: A word with in_last=0 whose data equals the escape word produces the escape word, then the control word 64'h0, then the original word.
- R4: A word equal to the escape word with in_last=1 is encoded as a marker: escape word, 64'h1, escape word.
- R5: After a word that needs escaping is accepted, in_ready stays low until its payload has entered the output buffer. With out_ready held high, in_ready is low for two cycles and high again on the third.
- R6: in_ready is a function of registered state only. Changing out_ready within a cycle does not change in_ready. When the buffer holds two words and out_ready is low, in_ready stays low.
- R7: Once out_valid is high, it stays high and out_data does not change until a cycle with out_ready high.
- R8: With out_ready held high, consecutive ordinary words are accepted on every cycle, with no stall.
- R9: After a synchronous reset, out_valid is 0 and in_ready is 1.
- R10: A one-cycle flush empties the buffer and drops any escape sequence in progress. On the next cycle out_valid is 0 and in_ready is 1, and none of the dropped words ever appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Synchronous clear of buffer and sequencer |
| in_data | input | 64 | Input word |
| in_last | input | 1 | Input word ends a packet |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take an input word |
| out_data | output | 64 | Encoded output word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the output word |

## Verification
The bench builds the block with its default parameters: a 64-bit word and the standard escape value. With these defaults, the escape word can be driven as literal data, both with and without last. A two-entry buffer fills within two stalled cycles, so random output backpressure often leaves an escape sequence parked half emitted with the buffer full. That state is where the flush, ready-hold and stall behaviour are exercised.

// File: rtl/tagfold_pkg.sv
package tagfold_pkg;
  // Sequencer phase: idle, emitting the control word, or emitting the payload
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_CTRL = 2'd1,
    SQ_PAY  = 2'd2
  } seq_state_e;

  localparam int unsigned BUF_SLOTS = 2;
endpackage

// File: rtl/tagfold_seq.sv
module tagfold_seq
  import tagfold_pkg::*;
#(
  parameter int unsigned          DATA_W   = 64,
  parameter logic [DATA_W-1:0]    ESC_WORD = 64'hDEADBEEFFEEDCAFE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              esc_start,
  output logic              push_valid,
  output logic [DATA_W-1:0] push_data,
  input  logic              push_ready
);
  // A word needs the three-word form when it ends a packet or collides with the escape word
  function automatic logic needs_escape(input logic [DATA_W-1:0] d, input logic last);
    return last || (d == ESC_WORD);
  endfunction

  // Control word: 1 marks the end of a packet, 0 marks literal data
  function automatic logic [DATA_W-1:0] ctrl_word(input logic is_marker);
    return {{(DATA_W-1){1'b0}}, is_marker};
  endfunction

  seq_state_e        state;
  logic [DATA_W-1:0] held_data;
  logic              held_last;
  logic              in_fire;

  assign in_ready  = (state == SQ_IDLE) && push_ready;
  assign in_fire   = in_valid && in_ready;
  assign esc_start = in_fire && needs_escape(in_data, in_last);

  always_comb begin
    push_valid = 1'b0;
    push_data  = in_data;
    unique case (state)
      SQ_IDLE: begin
        push_valid = in_valid;
        push_data  = needs_escape(in_data, in_last) ? ESC_WORD : in_data;
      end
      SQ_CTRL: begin
        push_valid = 1'b1;
        push_data  = ctrl_word(held_last);
      end
      SQ_PAY: begin
        push_valid = 1'b1;
        push_data  = held_data;
      end
      default: begin
        push_valid = 1'b0;
        push_data  = in_data;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      state <= SQ_IDLE;
    end else begin
      unique case (state)
        SQ_IDLE: if (esc_start) state <= SQ_CTRL;
        SQ_CTRL: if (push_ready) state <= SQ_PAY;
        SQ_PAY:  if (push_ready) state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (esc_start) begin
      held_data <= in_data;
      held_last <= in_last;
    end
  end
endmodule

// File: rtl/tagfold_buf2.sv
module tagfold_buf2
  import tagfold_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  output logic              push_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready
);
  localparam int unsigned CNT_W = $clog2(BUF_SLOTS + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BUF_SLOTS);

  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] slot_head, slot_tail;
  logic              push_fire, pop_fire;

  assign push_ready = (count != FULL_CNT);
  assign out_valid  = (count != '0);
  assign out_data   = slot_head;
  assign push_fire  = push_valid && push_ready;
  assign pop_fire   = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      count <= '0;
    end else begin
      unique case ({push_fire, pop_fire})
        2'b10: count <= count + 1'b1;
        2'b01: count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    unique case ({push_fire, pop_fire})
      2'b10: begin
        if (count == '0) slot_head <= push_data;
        else             slot_tail <= push_data;
      end
      2'b01: slot_head <= slot_tail;
      2'b11: slot_head <= push_data;
      default: ;
    endcase
  end

  p_valid_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !flush) |=> out_valid);

  p_data_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !flush) |=> $stable(out_data));
endmodule

// File: rtl/tagfold_inserter.sv
module tagfold_inserter
  import tagfold_pkg::*;
#(
  parameter int unsigned       DATA_W   = 64,
  parameter logic [DATA_W-1:0] ESC_WORD = 64'hDEADBEEFFEEDCAFE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready
);
  logic              esc_start;
  logic              push_valid, push_ready;
  logic [DATA_W-1:0] push_data;

  tagfold_seq #(.DATA_W(DATA_W), .ESC_WORD(ESC_WORD)) u_seq (
    .clk(clk), .rst(rst), .flush(flush),
    .in_data(in_data), .in_last(in_last), .in_valid(in_valid), .in_ready(in_ready),
    .esc_start(esc_start),
    .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready)
  );

  tagfold_buf2 #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst), .flush(flush),
    .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
  );

  p_busy_after_escape_r5: assert property (@(posedge clk) disable iff (rst)
    (esc_start && !flush) |=> !in_ready);

  p_full_stays_blocked_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !in_ready && !flush) |=> !in_ready);

  p_flush_empties_r10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!out_valid && in_ready));

  p_escape_then_control_r2: assert property (@(posedge clk) disable iff (rst)
    (esc_start && !flush) |=> push_valid);
endmodule

// File: tb/tagfold_inserter_tb.sv
`timescale 1ns/1ps
module tagfold_inserter_tb;
  localparam logic [63:0] ESC = 64'hDEADBEEFFEEDCAFE;

  logic clk = 1'b0, rst = 1'b1, flush = 1'b0;
  logic [63:0] in_data = '0;
  logic in_last = 1'b0, in_valid = 1'b0, in_ready;
  logic [63:0] out_data;
  logic out_valid, out_ready = 1'b1;

  always #2.5 clk = ~clk;

  tagfold_inserter u_dut (
    .clk(clk), .rst(rst), .flush(flush),
    .in_data(in_data), .in_last(in_last), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
  );

  int checks = 0, fails = 0, mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [63:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected encoding, written from the requirements
  function automatic void expect_word(input logic [63:0] d, input logic last);
    if (last) begin
      exp_q.push_back(ESC); exp_q.push_back(64'd1); exp_q.push_back(d);
      repeat (3) tag_q.push_back((d == ESC) ? "R4" : "R2");
    end else if (d == ESC) begin
      exp_q.push_back(ESC); exp_q.push_back(64'd0); exp_q.push_back(d);
      repeat (3) tag_q.push_back("R3");
    end else begin
      exp_q.push_back(d); tag_q.push_back("R1");
    end
  endfunction

  task automatic send(input logic [63:0] d, input logic last);
    expect_word(d, last);
    @(posedge clk); #1;
    in_data = d; in_last = last; in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int t = 0;
    while (exp_q.size() != 0 && t < 2000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R1", 64'(exp_q.size()), 64'd0);
  endtask

  // Output ready pattern: 0 always high, 1 pseudo-random, 2 manual, 3 always low
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (mode)
      0: out_ready = 1'b1;
      1: out_ready = lfsr[0] | lfsr[3];
      3: out_ready = 1'b0;
      default: ;
    endcase
  end

  // Scoreboard monitor
  bit hold_pend = 0;
  logic [63:0] hold_d;
  always @(negedge clk) begin
    if (rst) hold_pend = 0;
    else begin
      if (hold_pend) check(out_valid && out_data == hold_d, "R7", out_data, hold_d);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R1 unexpected word", out_data, 64'hX);
        else begin
          logic [63:0] e; string tg;
          e = exp_q.pop_front(); tg = tag_q.pop_front();
          check(out_data == e, tg, out_data, e);
        end
      end
      hold_pend = out_valid && !out_ready && !flush;
      hold_d = out_data;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int stalls;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9", 64'(out_valid), 64'd0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R9", 64'({in_ready, out_valid}), 64'd2);

    // R1..R4 basic patterns
    send(64'h0123_4567_89AB_CDEF, 1'b0);
    send(64'h0, 1'b0);
    send(ESC ^ 64'h1, 1'b0);
    send(64'h1111_2222_3333_4444, 1'b1);
    send(ESC, 1'b0);
    send(ESC, 1'b1);
    send(64'h1, 1'b1);
    drain();

    // R5: busy window after an escaped word
    send(64'hFACE, 1'b1);
    @(negedge clk); check(in_ready == 1'b0, "R5", 64'(in_ready), 64'd0);
    @(negedge clk); check(in_ready == 1'b0, "R5", 64'(in_ready), 64'd0);
    @(negedge clk); check(in_ready == 1'b1, "R5", 64'(in_ready), 64'd1);
    drain();

    // R8: back-to-back ordinary words with no stall
    stalls = 0;
    @(posedge clk); #1;
    for (int i = 0; i < 8; i++) begin
      in_data = 64'h5000 + 64'(i); in_last = 1'b0; in_valid = 1'b1;
      expect_word(in_data, 1'b0);
      @(negedge clk);
      while (!in_ready) begin stalls++; @(negedge clk); end
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    check(stalls == 0, "R8", 64'(stalls), 64'd0);
    drain();

    // Random mix under backpressure (R1-R4 data, R7 holds)
    mode = 1;
    for (int i = 0; i < 60; i++) begin
      logic [63:0] d;
      d = {lfsr, ~lfsr, lfsr ^ 16'h5A5A, 16'(i)};
      if (i % 7 == 3) d = ESC;
      send(d, (i % 5 == 1));
    end
    drain();

    // R6: out_ready toggling mid-cycle leaves in_ready alone
    mode = 2;
    @(posedge clk); #1 out_ready = 1'b0;
    send(64'hA1, 1'b0);
    begin
      logic r;
      r = in_ready;
      out_ready = 1'b1; #0.5;
      check(in_ready == r, "R6", 64'(in_ready), 64'(r));
      out_ready = 1'b0;
    end
    send(64'hA2, 1'b0);
    @(negedge clk); check(in_ready == 1'b0, "R6", 64'(in_ready), 64'd0);
    @(negedge clk); check(in_ready == 1'b0, "R6", 64'(in_ready), 64'd0);
    @(posedge clk); #1 out_ready = 1'b1; #0.5;
    check(in_ready == 1'b0, "R6", 64'(in_ready), 64'd0);
    mode = 0;
    drain();

    // R10: flush while an escape sequence is parked
    mode = 3;
    repeat (2) @(posedge clk);
    send(64'hBEEF, 1'b1);
    repeat (3) @(posedge clk);
    #1 flush = 1'b1;
    exp_q.delete(); tag_q.delete();
    @(posedge clk); #1 flush = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R10", 64'({out_valid, in_ready}), 64'd1);
    mode = 0;
    send(64'hC0DE, 1'b0);
    drain();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule